// File: doc/BRIEF.md
# Double-Buffered Multichannel Converter Register Bank

This block keeps two registers per converter channel: a code register that commands write into, and an output register that drives the converter. Eight channels share one write port. The port carries a channel index, an operation code, a 16-bit data word and a strobe. Two active-low inputs can arrive at any time and act across all channels. The load input moves code values into the output registers. The clear input forces channels back to a selectable default value. Each channel has its own configuration bits, which decide whether it answers load, clear or both.

Both inputs pass through two-flop synchronizers before they take effect. A load held low makes the output register follow the code register, so a code write reaches the converter in the same clock as the write. An active clear drops writes aimed at clear-enabled channels. It keeps dropping them for a short setup window after release. A strap input picks the power-on contents of every code and output register: zero or midscale.

Top module: `dac_regbank`

## Requirements
- R1: After reset, every code and output register holds zero when `strap_mid` is low and 12'h800 when it is high. Every default selector resets to zero. Both enable bits of every channel reset to 1.
- R2: A low level on `load_n` copies each load-enabled channel's code register into its output register. The output changes at the third rising clock edge after `load_n` is first sampled low, not at the second.
- R3: While `load_n` stays low, a code write to a load-enabled channel updates that channel's output register at the same edge that updates its code register.
- R4: A channel whose load-enable bit is 0 keeps its output register unchanged through a load, and its code register keeps any value written meanwhile.
- R5: A low level on `clear_n` sets both registers of each clear-enabled channel to that channel's default. The registers change at the third rising edge after `clear_n` is first sampled low. Default selector encoding: 0 gives zero, 1 gives midscale 12'h800, 2 gives full scale 12'hFFF, 3 gives the stored default value.
- R6: A channel whose clear-enable bit is 0 keeps both registers through a clear, and it still accepts writes while the clear is active.
- R7: A write to a clear-enabled channel is discarded while the synchronized clear is active. It is also discarded for `CLR_HOLD` (default 4) cycles after the synchronized clear goes inactive. Later writes are accepted.
- R8: When synchronized clear and load are active in the same cycle, clear wins, and clear-enabled channels show their default value.
- R9: Write operations use the `wr_op` encoding: 0 writes the code, 1 writes the configuration (data bit 0 = load enable, bit 1 = clear enable), 2 writes the default selector (data bits 1:0), and 3 writes the stored default. Code and stored default take data bits 15:4 and ignore bits 3:0.
- R10: Output registers change only through an active synchronized load or clear. Code writes made with both inactive leave `dac_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| strap_mid | input | 1 | Power-on value select: 0 zero scale, 1 midscale |
| load_n | input | 1 | Asynchronous active-low load request |
| clear_n | input | 1 | Asynchronous active-low clear request |
| wr_en | input | 1 | Write strobe, one cycle per command |
| wr_op | input | 2 | Write operation code |
| wr_ch | input | 3 | Target channel index |
| wr_data | input | 16 | Left-justified write data |
| dac_out | output | 96 | Output registers, channel n in bits n*12+11 down to n*12 |

## Verification
Clear and load can be active in the same cycle, and so can a clear and a write to a clear-enabled channel. The bench lowers `load_n` and `clear_n` at the same falling edge after writing a fresh code. It then expects the default rather than the code on the clear-enabled channel. The bench also issues writes while clear is held, and again inside the setup window after release. A later load then exposes the code register, and the bench judges whether those writes were dropped.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    typedef enum logic [1:0] {
        DSEL_ZERO   = 2'd0,
        DSEL_MID    = 2'd1,
        DSEL_FULL   = 2'd2,
        DSEL_STORED = 2'd3
    } dsel_e;

    typedef enum logic [1:0] {
        OP_CODE = 2'd0,
        OP_CFG  = 2'd1,
        OP_DSEL = 2'd2,
        OP_DVAL = 2'd3
    } wr_op_e;

endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.s2;
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
    import dacbank_pkg::*;
#(
    parameter int DW = 12,
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_mid,
    input  logic          clr_act,
    input  logic          ld_act,
    input  logic          hold_busy,
    input  logic          sel,
    input  logic          wr_en,
    input  logic [1:0]    wr_op,
    input  logic [FW-1:0] wr_data,
    output logic [DW-1:0] out_o,
    output logic [DW-1:0] code_o,
    output logic          ld_en_o
);
    localparam logic [DW-1:0] MIDV  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] FULLV = '1;

    typedef struct packed {
        logic [DW-1:0] code;
        logic [DW-1:0] outv;
        logic          ld_en;
        logic          clr_en;
        dsel_e         dsel;
        logic [DW-1:0] dval;
    } chan_t;

    chan_t         ch_d, ch_q;
    logic [DW-1:0] dflt;
    logic [DW-1:0] wval;
    logic          accept;
    logic          unused_low;

    assign unused_low = ^wr_data[FW-DW-1:0];

    always_comb begin
        wval = wr_data[FW-1 -: DW];
        case (ch_q.dsel)
            DSEL_ZERO: dflt = '0;
            DSEL_MID:  dflt = MIDV;
            DSEL_FULL: dflt = FULLV;
            default:   dflt = ch_q.dval;
        endcase
        accept = sel && wr_en && !(ch_q.clr_en && (clr_act || hold_busy));

        ch_d = ch_q;
        if (accept) begin
            case (wr_op_e'(wr_op))
                OP_CODE: ch_d.code = wval;
                OP_CFG: begin
                    ch_d.ld_en  = wr_data[0];
                    ch_d.clr_en = wr_data[1];
                end
                OP_DSEL: ch_d.dsel = dsel_e'(wr_data[1:0]);
                default: ch_d.dval = wval;
            endcase
        end
        if (clr_act && ch_q.clr_en) begin
            ch_d.code = dflt;
            ch_d.outv = dflt;
        end else if (ld_act && ch_q.ld_en) begin
            ch_d.outv = ch_d.code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q.code   <= strap_mid ? MIDV : '0;
            ch_q.outv   <= strap_mid ? MIDV : '0;
            ch_q.ld_en  <= 1'b1;
            ch_q.clr_en <= 1'b1;
            ch_q.dsel   <= DSEL_ZERO;
            ch_q.dval   <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign out_o   = ch_q.outv;
    assign code_o  = ch_q.code;
    assign ld_en_o = ch_q.ld_en;
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank #(
    parameter int NCH      = 8,
    parameter int DW       = 12,
    parameter int FW       = 16,
    parameter int CLR_HOLD = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strap_mid,
    input  logic                   load_n,
    input  logic                   clear_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_op,
    input  logic [$clog2(NCH)-1:0] wr_ch,
    input  logic [FW-1:0]          wr_data,
    output logic [NCH*DW-1:0]      dac_out
);
    localparam int CW = $clog2(NCH);
    localparam int HW = $clog2(CLR_HOLD + 1);

    typedef struct packed {
        logic [HW-1:0] hold;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic [1:0]        req_s;
    logic              clr_act;
    logic              ld_act;
    logic              hold_busy;
    logic [HW-1:0]     hold_cnt;
    logic [NCH-1:0]    ld_en_v;
    logic [NCH*DW-1:0] code_v;

    dacbank_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({~clear_n, ~load_n}),
        .dout (req_s)
    );

    assign clr_act = req_s[1];
    assign ld_act  = req_s[0];

    always_comb begin
        ctl_d = ctl_q;
        if (clr_act)              ctl_d.hold = HW'(CLR_HOLD);
        else if (ctl_q.hold != 0) ctl_d.hold = ctl_q.hold - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign hold_cnt  = ctl_q.hold;
    assign hold_busy = (ctl_q.hold != 0);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dacbank_chan #(.DW(DW), .FW(FW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .strap_mid(strap_mid),
            .clr_act  (clr_act),
            .ld_act   (ld_act),
            .hold_busy(hold_busy),
            .sel      (wr_ch == CW'(g)),
            .wr_en    (wr_en),
            .wr_op    (wr_op),
            .wr_data  (wr_data),
            .out_o    (dac_out[g*DW +: DW]),
            .code_o   (code_v[g*DW +: DW]),
            .ld_en_o  (ld_en_v[g])
        );
    end
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
    parameter int NCH      = 8,
    parameter int DW       = 12,
    parameter int CLR_HOLD = 4,
    parameter int HW       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_n,
    input logic              clr_act,
    input logic              ld_act,
    input logic [HW-1:0]     hold_cnt,
    input logic [NCH-1:0]    ld_en_v,
    input logic [NCH*DW-1:0] code_v,
    input logic [NCH*DW-1:0] dac_out
);
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_act && !clr_act) |=> $stable(dac_out));

    // R5
    clr_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |-> $past(!clear_n, 2));

    // R7
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_act) |-> (hold_cnt == HW'(CLR_HOLD)));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R3
        load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_act && !clr_act && ld_en_v[i]) |=>
            (dac_out[i*DW +: DW] == code_v[i*DW +: DW]));
    end
endmodule

bind dac_regbank dac_regbank_chk #(
    .NCH(NCH), .DW(DW), .CLR_HOLD(CLR_HOLD), .HW($clog2(CLR_HOLD + 1))
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_n (clear_n),
    .clr_act (clr_act),
    .ld_act  (ld_act),
    .hold_cnt(hold_cnt),
    .ld_en_v (ld_en_v),
    .code_v  (code_v),
    .dac_out (dac_out)
);

// File: tb/tb_dac_regbank.sv
module tb_dac_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_mid = 1'b0;
    logic        load_n = 1'b1;
    logic        clear_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_op = 2'd0;
    logic [2:0]  wr_ch = 3'd0;
    logic [15:0] wr_data = 16'h0;
    logic [95:0] dac_out;

    int checks = 0;
    int errors = 0;

    dac_regbank dut (
        .clk(clk), .rst_n(rst_n), .strap_mid(strap_mid), .load_n(load_n),
        .clear_n(clear_n), .wr_en(wr_en), .wr_op(wr_op), .wr_ch(wr_ch),
        .wr_data(wr_data), .dac_out(dac_out)
    );

    always #10 clk = ~clk;

    function automatic logic [11:0] chv(input int i);
        return dac_out[i*12 +: 12];
    endfunction

    function automatic logic [11:0] vpat(input int i);
        return 12'h1A0 + 12'(i) * 12'h111;
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] op, input int ch, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_op = op; wr_ch = 3'(ch); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_load;
        @(negedge clk); load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
        idle(3);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; strap_mid = strap;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset(input logic strap);
        do_reset(strap);
        for (int i = 0; i < 8; i++)
            check("R1 reset value", chv(i), strap ? 12'h800 : 12'h000);
    endtask

    task automatic t_load;
        for (int i = 0; i < 8; i++) wr(2'd0, i, {vpat(i), 4'hF});
        for (int i = 0; i < 8; i++) check("R10 write without load", chv(i), 12'h800);
        @(negedge clk); load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
        @(negedge clk);
        check("R2 not before third edge", chv(0), 12'h800);
        @(negedge clk);
        for (int i = 0; i < 8; i++) check("R2/R9 load copy", chv(i), vpat(i));
        idle(2);
    endtask

    task automatic t_transparent;
        @(negedge clk); load_n = 1'b0;
        idle(3);
        wr(2'd0, 2, 16'hC3C0);
        check("R3 transparent write", chv(2), 12'hC3C);
        load_n = 1'b1;
        idle(3);
    endtask

    task automatic t_load_mask;
        wr(2'd1, 1, 16'h0002);
        wr(2'd0, 1, 16'h9990);
        pulse_load();
        check("R4 load disabled", chv(1), vpat(1));
        wr(2'd1, 1, 16'h0003);
        pulse_load();
        check("R4 code kept", chv(1), 12'h999);
    endtask

    task automatic t_clear;
        wr(2'd2, 1, 16'h0001);
        wr(2'd2, 2, 16'h0002);
        wr(2'd2, 3, 16'h0003);
        wr(2'd3, 3, 16'h5A5A);
        wr(2'd1, 4, 16'h0001);
        @(negedge clk); clear_n = 1'b0;
        idle(3);
        check("R5 sel zero", chv(0), 12'h000);
        check("R5 sel mid", chv(1), 12'h800);
        check("R5 sel full", chv(2), 12'hFFF);
        check("R5 sel stored", chv(3), 12'h5A5);
        check("R6 clear disabled", chv(4), vpat(4));
        check("R5 reset selector", chv(5), 12'h000);
        wr(2'd0, 0, 16'h1230);
        wr(2'd0, 4, 16'h4440);
        @(negedge clk); clear_n = 1'b1;
        idle(2);
        wr(2'd0, 5, 16'h6660);
        idle(8);
        pulse_load();
        check("R7 dropped during clear", chv(0), 12'h000);
        check("R7 dropped in setup window", chv(5), 12'h000);
        check("R6 write accepted in clear", chv(4), 12'h444);
        wr(2'd0, 5, 16'h5C50);
        pulse_load();
        check("R7 accepted after window", chv(5), 12'h5C5);
    endtask

    task automatic t_priority;
        wr(2'd0, 6, 16'h7770);
        @(negedge clk); load_n = 1'b0; clear_n = 1'b0;
        idle(3);
        check("R8 clear over load", chv(6), 12'h000);
        check("R8 clear over load mid", chv(1), 12'h800);
        @(negedge clk); load_n = 1'b1; clear_n = 1'b1;
        idle(8);
        check("R10 stable after release", chv(6), 12'h000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset(1'b1);
        t_load();
        t_transparent();
        t_load_mask();
        t_clear();
        t_priority();
        t_reset(1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule